// File: doc/BRIEF.md
# Segment Selector Bounds and Null Checker

This block sits in the segment-load path of a protected-mode address unit. It holds the base and byte-granular limit of one descriptor table and judges each selector index that software loads into one of several data-segment registers. A selector whose whole 8-byte descriptor lies inside the table yields the descriptor's byte address, for the fetch logic downstream. A selector that reaches past the limit raises a general-protection fault instead.

Index 0 names the null entry, which is never fetched. Loading it is legal and silent. The block keeps a one-bit tag per segment register that records a null load. Any later memory access through that register then faults. Loads and accesses are separate requests, each with a valid/ready pair. A load wins when both arrive in the same cycle. Every result appears one cycle after the request is accepted.

Top module: `seg_sel_chk`

## Requirements
- R1: An accepted load with a nonzero index that is in range pulses `desc_vld` for one cycle, one cycle later, with `desc_addr` = base + index*8, taken modulo 2^ADDR_W.
- R2: A nonzero index is in range only when index*8+7 <= limit. Otherwise the load pulses `flt_vld` with `flt_code` = 1 (limit) and gives no `desc_vld`.
- R3: With a limit of 0, every nonzero index faults with code 1.
- R4: Limits that are not of the form 8N-1 are handled per byte. With limit 20, index 1 is accepted and index 2 faults with code 1.
- R5: A load of index 0 raises neither `flt_vld` nor `desc_vld`, whatever the limit, and marks that segment register as null.
- R6: An accepted access through a segment register tagged null pulses `flt_vld` with `flt_code` = 2 (null use) one cycle later.
- R7: An access through a register whose last successful load was in range gives no fault. Each register's tag is independent of the others.
- R8: A load that faults leaves the target register's tag as it was.
- R9: Reset clears base and limit, tags every register null, and holds `desc_vld` and `flt_vld` low.
- R10: `ld_rdy` is always 1. `acc_rdy` is 0 whenever `ld_vld` is 1, and an access refused that way has no effect.
- R11: `flt_vld` and `desc_vld` are never high together. Each high cycle follows an accepted request in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the table base and limit |
| cfg_base | input | ADDR_W | New table base byte address |
| cfg_lim | input | LIM_W | New table limit (offset of the last valid byte) |
| ld_vld | input | 1 | Segment-load request valid |
| ld_rdy | output | 1 | Segment-load request ready |
| ld_seg | input | $clog2(NSEG) | Segment register being loaded |
| ld_idx | input | IDX_W | Selector index being loaded |
| acc_vld | input | 1 | Memory-access request valid |
| acc_rdy | output | 1 | Memory-access request ready |
| acc_seg | input | $clog2(NSEG) | Segment register used by the access |
| desc_vld | output | 1 | Descriptor address valid pulse |
| desc_addr | output | ADDR_W | Byte address of the selected descriptor |
| flt_vld | output | 1 | General-protection fault pulse |
| flt_code | output | 2 | Fault cause: 1 limit, 2 null use |

## Verification
The loads use indices on both sides of the limit, at three different limits. One is a table of exactly eight entries, where index 7 passes and index 8 fails. One is the odd limit 20, where a descriptor is only partly inside the table. The last is the cleared limit 0, which keeps out every nonzero index and so separates the null case from the bounds case. Accesses come after null loads, in-range loads and failed loads, which shows that only a successful non-null load clears a tag and that the tags do not interfere with each other. A sweep of indices from a base near the top of the address space checks the address arithmetic across wraparound. Simultaneous load and access requests show that the access is refused without effect.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_NULL  = 2'd2
  } flt_e;
endpackage

// File: rtl/sds_bound.sv
// Decides whether all 8 bytes of descriptor idx fall at or below the limit.
module sds_bound #(
  parameter int IDX_W = 13,
  parameter int LIM_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LIM_W-1:0] lim,
  output logic             in_range
);
  localparam int CW = ((IDX_W + 3) > LIM_W) ? (IDX_W + 3) : LIM_W;

  logic [CW-1:0] last_byte;
  logic [CW-1:0] lim_ext;

  always_comb begin
    last_byte = CW'({idx, 3'b111});
    lim_ext   = CW'(lim);
    in_range  = (last_byte <= lim_ext);
  end
endmodule

// File: rtl/sds_addr.sv
// Descriptor byte address: base plus index scaled by the 8-byte entry size.
module sds_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int SW = ((IDX_W + 3) > ADDR_W) ? (IDX_W + 3) : ADDR_W;

  logic [SW-1:0] offs;

  always_comb begin
    offs = SW'({idx, 3'b000});
    addr = base + offs[ADDR_W-1:0];
  end
endmodule

// File: rtl/sds_tags.sv
// One null tag per segment register; set on reset and on a null load.
module sds_tags #(
  parameter int NSEG = 4,
  localparam int SW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [SW-1:0] rd_sel,
  output logic          rd_tag
);
  logic [NSEG-1:0] tag_q;
  logic [NSEG-1:0] tag_d;

  for (genvar g = 0; g < NSEG; g++) begin : g_tag
    always_comb begin
      tag_d[g] = tag_q[g];
      if (wr_sel == SW'(g)) begin
        if (set_en)      tag_d[g] = 1'b1;
        else if (clr_en) tag_d[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q[g] <= 1'b1;
      else        tag_q[g] <= tag_d[g];
    end
  end

  assign rd_tag = tag_q[rd_sel];
endmodule

// File: rtl/seg_sel_chk.sv
module seg_sel_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 13,
  parameter int LIM_W  = 16,
  parameter int NSEG   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_base,
  input  logic [LIM_W-1:0]        cfg_lim,
  input  logic                    ld_vld,
  output logic                    ld_rdy,
  input  logic [$clog2(NSEG)-1:0] ld_seg,
  input  logic [IDX_W-1:0]        ld_idx,
  input  logic                    acc_vld,
  output logic                    acc_rdy,
  input  logic [$clog2(NSEG)-1:0] acc_seg,
  output logic                    desc_vld,
  output logic [ADDR_W-1:0]       desc_addr,
  output logic                    flt_vld,
  output logic [1:0]              flt_code
);
  import sds_pkg::*;

  localparam int SW = $clog2(NSEG);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [LIM_W-1:0]  lim_q, lim_d;
  logic              dv_q, dv_d;
  logic [ADDR_W-1:0] da_q, da_d;
  logic              da_en;
  logic              fv_q, fv_d;
  flt_e              fc_q, fc_d;

  logic              ld_go, acc_go, ld_null, in_range, acc_tag;
  logic              tag_set, tag_clr;
  logic [ADDR_W-1:0] calc_addr;

  assign ld_rdy  = 1'b1;
  assign acc_rdy = ~ld_vld;
  assign ld_go   = ld_vld;
  assign acc_go  = acc_vld & ~ld_vld;
  assign ld_null = (ld_idx == '0);

  sds_bound #(.IDX_W(IDX_W), .LIM_W(LIM_W)) u_bound (
    .idx(ld_idx), .lim(lim_q), .in_range(in_range)
  );

  sds_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base(base_q), .idx(ld_idx), .addr(calc_addr)
  );

  assign tag_set = ld_go & ld_null;
  assign tag_clr = ld_go & ~ld_null & in_range;

  sds_tags #(.NSEG(NSEG)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .set_en(tag_set), .clr_en(tag_clr),
    .wr_sel(SW'(ld_seg)), .rd_sel(SW'(acc_seg)),
    .rd_tag(acc_tag)
  );

  always_comb begin
    base_d = cfg_we ? cfg_base : base_q;
    lim_d  = cfg_we ? cfg_lim  : lim_q;
    dv_d   = 1'b0;
    da_en  = 1'b0;
    da_d   = calc_addr;
    fv_d   = 1'b0;
    fc_d   = FLT_NONE;
    if (ld_go && !ld_null) begin
      if (in_range) begin
        dv_d  = 1'b1;
        da_en = 1'b1;
      end else begin
        fv_d = 1'b1;
        fc_d = FLT_LIMIT;
      end
    end else if (acc_go && acc_tag) begin
      fv_d = 1'b1;
      fc_d = FLT_NULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      dv_q   <= 1'b0;
      da_q   <= '0;
      fv_q   <= 1'b0;
      fc_q   <= FLT_NONE;
    end else begin
      base_q <= base_d;
      lim_q  <= lim_d;
      dv_q   <= dv_d;
      if (da_en) da_q <= da_d;
      fv_q   <= fv_d;
      fc_q   <= fc_d;
    end
  end

  assign desc_vld  = dv_q;
  assign desc_addr = da_q;
  assign flt_vld   = fv_q;
  assign flt_code  = fc_q;
endmodule

// File: rtl/sds_chk.sv
module sds_chk #(
  parameter int IDX_W = 13,
  parameter int NSEG  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_vld,
  input logic                    ld_rdy,
  input logic [IDX_W-1:0]        ld_idx,
  input logic                    acc_vld,
  input logic                    acc_rdy,
  input logic                    acc_tag,
  input logic                    desc_vld,
  input logic                    flt_vld,
  input logic [1:0]              flt_code
);
  a_r10_ld_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rdy);

  a_r10_load_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> !acc_rdy);

  a_r11_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_vld && flt_vld));

  a_r11_flt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_vld) |-> $past((ld_vld && ld_rdy) || (acc_vld && acc_rdy)));

  a_r1_desc_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_rdy && ld_idx == '0) |=> !desc_vld);

  a_r5_null_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_rdy && ld_idx == '0) |=> !flt_vld);

  a_r6_null_use_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_rdy && acc_tag) |=> (flt_vld && flt_code == 2'd2));

  a_r2_limit_code_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && flt_code == 2'd1) |-> $past(ld_vld && ld_idx != '0));
endmodule

bind seg_sel_chk sds_chk #(.IDX_W(IDX_W), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_vld(ld_vld), .ld_rdy(ld_rdy), .ld_idx(ld_idx),
  .acc_vld(acc_vld), .acc_rdy(acc_rdy), .acc_tag(acc_tag),
  .desc_vld(desc_vld), .flt_vld(flt_vld), .flt_code(flt_code)
);

// File: tb/seg_sel_chk_test.sv
module seg_sel_chk_test;
  localparam int AW = 32;
  localparam int IW = 13;
  localparam int LW = 16;

  typedef struct {
    logic          dv;
    logic [AW-1:0] a;
    logic          fv;
    logic [1:0]    fc;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_base;
  logic [LW-1:0] cfg_lim;
  logic          ld_vld, acc_vld;
  logic          ld_rdy, acc_rdy;
  logic [1:0]    ld_seg, acc_seg;
  logic [IW-1:0] ld_idx;
  logic          desc_vld, flt_vld;
  logic [AW-1:0] desc_addr;
  logic [1:0]    flt_code;

  int total = 0;
  int bad   = 0;

  exp_t          q[$];
  logic [AW-1:0] base_m;
  logic [LW-1:0] lim_m;
  logic [3:0]    tag_m;

  always #5 clk = ~clk;

  seg_sel_chk uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_lim(cfg_lim), .ld_vld(ld_vld), .ld_rdy(ld_rdy), .ld_seg(ld_seg),
    .ld_idx(ld_idx), .acc_vld(acc_vld), .acc_rdy(acc_rdy),
    .acc_seg(acc_seg), .desc_vld(desc_vld), .desc_addr(desc_addr),
    .flt_vld(flt_vld), .flt_code(flt_code)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: compares each expected item with the outputs after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(desc_vld == e.dv, {e.req, " desc_vld"}, AW'(desc_vld), AW'(e.dv));
        if (e.dv) chk(desc_addr == e.a, {e.req, " desc_addr"}, desc_addr, e.a);
        chk(flt_vld == e.fv, {e.req, " flt_vld"}, AW'(flt_vld), AW'(e.fv));
        if (e.fv) chk(flt_code == e.fc, {e.req, " flt_code"}, AW'(flt_code), AW'(e.fc));
      end
    end
  end

  task automatic push(input logic dv, input logic [AW-1:0] a, input logic fv,
                      input logic [1:0] fc, input string req);
    exp_t e;
    e.dv = dv; e.a = a; e.fv = fv; e.fc = fc; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_in();
    cfg_we = 1'b0; ld_vld = 1'b0; acc_vld = 1'b0;
  endtask

  task automatic cfg(input logic [AW-1:0] b, input logic [LW-1:0] l);
    @(negedge clk);
    idle_in();
    cfg_we = 1'b1; cfg_base = b; cfg_lim = l;
    base_m = b; lim_m = l;
    push(1'b0, '0, 1'b0, 2'd0, "R9 cfg cycle");
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    idle_in();
    push(1'b0, '0, 1'b0, 2'd0, req);
  endtask

  // load with optional concurrent access (which must be refused)
  task automatic load(input logic [1:0] s, input logic [IW-1:0] idx,
                      input bit with_acc, input string req);
    logic [18:0] last;
    @(negedge clk);
    idle_in();
    ld_vld = 1'b1; ld_seg = s; ld_idx = idx;
    if (with_acc) begin acc_vld = 1'b1; acc_seg = 2'd0; end
    last = {3'b000, idx, 3'b111};
    if (idx == '0) begin
      tag_m[s] = 1'b1;
      push(1'b0, '0, 1'b0, 2'd0, req);
    end else if (last <= 19'(lim_m)) begin
      tag_m[s] = 1'b0;
      push(1'b1, base_m + {16'd0, idx, 3'b000}, 1'b0, 2'd0, req);
    end else begin
      push(1'b0, '0, 1'b1, 2'd1, req);
    end
  endtask

  task automatic access(input logic [1:0] s, input string req);
    @(negedge clk);
    idle_in();
    acc_vld = 1'b1; acc_seg = s;
    push(1'b0, '0, tag_m[s], tag_m[s] ? 2'd2 : 2'd0, req);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    cfg_base = '0; cfg_lim = '0; ld_seg = '0; ld_idx = '0; acc_seg = '0;
    base_m = '0; lim_m = '0; tag_m = 4'hF;
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk(!desc_vld && !flt_vld, "R9 reset outputs", AW'({desc_vld, flt_vld}), '0);
    chk(ld_rdy == 1'b1, "R10 ld_rdy", AW'(ld_rdy), 1);
    chk(acc_rdy == 1'b1, "R10 acc_rdy idle", AW'(acc_rdy), 1);
    rst_n = 1'b1;

    // R9/R6: every register null after reset
    for (int s = 0; s < 4; s++) access(2'(s), "R9 R6 post-reset access");
    // R9/R3: limit cleared to 0
    load(2'd0, 13'd1, 1'b0, "R9 R3 limit zero after reset");
    load(2'd0, 13'd0, 1'b0, "R5 null load at limit 0");

    // eight-entry table
    cfg(32'h1000_0000, 16'h003F);
    load(2'd1, 13'd7, 1'b0, "R1 R2 last entry in range");
    load(2'd2, 13'd8, 1'b0, "R2 first entry past limit");
    access(2'd1, "R7 access after good load");
    access(2'd2, "R8 tag kept after failed load");
    access(2'd0, "R7 other register still null");
    load(2'd1, 13'd0, 1'b0, "R5 null reload");
    access(2'd1, "R6 access after null load");
    idle("R11 pulse ends");

    // odd limit
    cfg(32'h2000_0100, 16'd20);
    load(2'd3, 13'd1, 1'b0, "R4 entry inside odd limit");
    load(2'd2, 13'd2, 1'b0, "R4 entry partly outside");
    load(2'd2, 13'd3, 1'b0, "R4 entry fully outside");
    idle("R11 pulse ends after fault");
    access(2'd3, "R7 register 3 usable");

    // both requests at once: access refused
    load(2'd2, 13'd1, 1'b1, "R10 load wins");
    #1;
    chk(acc_rdy == 1'b0, "R10 acc_rdy low", AW'(acc_rdy), 0);
    access(2'd2, "R7 register 2 loaded under contention");

    // R3 after explicit limit 0
    cfg(32'h3000_0000, 16'd0);
    load(2'd1, 13'd1, 1'b0, "R3 limit 0 nonzero index");
    load(2'd1, 13'd8191, 1'b0, "R3 limit 0 top index");

    // sweep near wraparound
    cfg(32'hFFFF_FFC0, 16'h007F);
    for (int i = 1; i < 20; i++) load(2'(i % 4), 13'(i), 1'b0, "R1 R2 sweep");
    for (int s = 0; s < 4; s++) access(2'(s), "R7 sweep access");
    idle("R11 tail");
    idle("R11 tail");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 all results seen", AW'(q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule